// File: doc/BRIEF.md
# Prescaled Dual Reload Timer

This block holds two independent 16-bit down-counting timers. Both share one prescaler that divides the system clock by 20, so an enabled counter steps down by one only once in every 20 clocks. When a counter is at zero and a prescaler tick arrives, the counter reloads from its own reload register and raises that channel's terminal-count flag. If the channel's interrupt enable is set, a raised flag drives the channel's interrupt line.

Channel 1 also drives a waveform pin. While the pin is enabled, each terminal count of channel 1 inverts it, which gives a square wave with a period of 2 × 20 × (reload + 1) clocks. Software reaches the counters, the reload registers and one control/status register through a 16-bit bus. Software can write a counter at any time, so the first period can differ from the periods that follow. A change to a reload register only takes effect at the next reload.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset, both counters and both reload registers read 16'hFFFF. The control register reads 0, both irq_o bits are 0 and wave_o is 0.
- R2: The prescaler issues one tick every 20 clocks, and no counter changes value between ticks except through a bus write.
- R3: On a tick, a counter decrements by one while its enable bit is set. With the enable bit clear, the counter holds its value.
- R4: On a tick, an enabled counter at zero loads its reload value and sets its terminal-count flag. A flag set in this way stays set until it is cleared.
- R5: irq_o[n] is 1 exactly when channel n's terminal-count flag and interrupt-enable bit are both set.
- R6: A flag clears only after two reads in order: a read of the control register while the flag is set, then a read of that channel's counter. If a terminal count happens in the cycle of the counter read, the flag stays set. A counter read with no status read before it leaves the flag unchanged.
- R7: While the wave-enable bit is set, wave_o inverts on every channel 1 terminal count, so one period lasts 40 × (reload1 + 1) clocks. Otherwise wave_o holds its level.
- R8: A reload-register write leaves the current count untouched. The new value is used at the next reload.
- R9: A counter write takes effect in the cycle after the write and wins over a tick in the same cycle. That same-cycle tick produces no terminal count.
- R10: Register map (addr_i): 0 counter0, 1 reload0, 2 counter1, 3 reload1, 4 control. Addresses 5 to 7 read 0. Control bits: [0] enable0, [1] enable1, [2] int-enable0, [3] int-enable1, [4] wave-enable, [8] flag0, [9] flag1 (read-only). The other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe; triggers flag-clear side effects |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| irq_o | output | 2 | Per-channel interrupt |
| wave_o | output | 1 | Channel 1 waveform output |

## Verification
The embedded assertions check five things on every cycle: ticks never come back to back, the prescaler count stays in range, a disabled counter holds, a zero count reloads with the flag set, and a reload write leaves the count untouched. They also check that wave_o moves only on a channel 1 terminal count. Only the bench's scenarios can show the rest, because each depends on a sequence: the exact 20-clock spacing of counter steps, the two-read order that clears a flag, the measured square-wave period, and the first period set by a counter write before the reloaded periods.

// File: rtl/prt_pkg.sv
package prt_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CNT0 = 3'd0;
  localparam logic [ADDR_W-1:0] A_RLD0 = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT1 = 3'd2;
  localparam logic [ADDR_W-1:0] A_RLD1 = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd4;

  localparam int unsigned B_EN   = 0;  // +channel
  localparam int unsigned B_IE   = 2;  // +channel
  localparam int unsigned B_WAVE = 4;
  localparam int unsigned B_FLAG = 8;  // +channel
  localparam int unsigned CTRL_W = 5;
endpackage

// File: rtl/prt_prescaler.sv
module prt_prescaler #(
  parameter int unsigned DIV = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick_o = (pre_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (tick_o) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  a_r2_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  a_r2_pre_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= LAST);
endmodule

// File: rtl/prt_channel.sv
module prt_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             wr_cnt_i,
  input  logic             wr_rld_i,
  input  logic             rd_cnt_i,
  input  logic             rd_stat_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rld_o,
  output logic             flag_o,
  output logic             tc_o
);
  logic [CNT_W-1:0] cnt_q, rld_q;
  logic             flag_q, arm_q;

  assign tc_o = tick_i && en_i && (cnt_q == '0) && !wr_cnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      rld_q <= '1;
    end else begin
      if (wr_cnt_i)             cnt_q <= wdata_i;
      else if (tc_o)            cnt_q <= rld_q;
      else if (tick_i && en_i)  cnt_q <= cnt_q - 1'b1;
      if (wr_rld_i)             rld_q <= wdata_i;
    end
  end

  // flag clears only after status read followed by counter read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (tc_o)                    flag_q <= 1'b1;
      else if (rd_cnt_i && arm_q)  flag_q <= 1'b0;
      if (rd_stat_i)               arm_q  <= flag_q;
      else if (rd_cnt_i)           arm_q  <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign rld_o  = rld_q;
  assign flag_o = flag_q;

  a_r3_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wr_cnt_i) |=> $stable(cnt_o));
  a_r4_reload_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && en_i && cnt_o == '0 && !wr_cnt_i) |=> (cnt_o == $past(rld_o) && flag_o));
  a_r8_reload_no_disturb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_rld_i && !tick_i && !wr_cnt_i) |=> $stable(cnt_o));
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import prt_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DIV   = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic [1:0]        irq_o,
  output logic              wave_o
);
  localparam int unsigned NCH = 2;

  logic              tick;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cnt   [NCH];
  logic [CNT_W-1:0]  rld   [NCH];
  logic [NCH-1:0]    flag, tc;
  logic              wave_q;

  prt_prescaler #(.DIV(DIV)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] AC = ADDR_W'(2 * i);
    localparam logic [ADDR_W-1:0] AR = ADDR_W'(2 * i + 1);
    prt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .en_i     (ctrl_q[B_EN+i]),
      .wr_cnt_i (wr_i && addr_i == AC),
      .wr_rld_i (wr_i && addr_i == AR),
      .rd_cnt_i (rd_i && addr_i == AC),
      .rd_stat_i(rd_i && addr_i == A_CTRL),
      .wdata_i  (wdata_i),
      .cnt_o    (cnt[i]),
      .rld_o    (rld[i]),
      .flag_o   (flag[i]),
      .tc_o     (tc[i])
    );
    assign irq_o[i] = flag[i] && ctrl_q[B_IE+i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      wave_q <= 1'b0;
    end else begin
      if (wr_i && addr_i == A_CTRL) ctrl_q <= wdata_i[CTRL_W-1:0];
      if (tc[1] && ctrl_q[B_WAVE])  wave_q <= ~wave_q;
    end
  end

  assign wave_o = wave_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CNT0: rdata_o = cnt[0];
      A_RLD0: rdata_o = rld[0];
      A_CNT1: rdata_o = cnt[1];
      A_RLD1: rdata_o = rld[1];
      A_CTRL: begin
        rdata_o[CTRL_W-1:0]      = ctrl_q;
        rdata_o[B_FLAG+:NCH]     = flag;
      end
      default: rdata_o = '0;
    endcase
  end

  a_r7_wave_on_tc_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tc[1] |=> $stable(wave_o));
  a_r5_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[0] |-> flag[0]);
endmodule

// File: tb/dual_reload_timer_bench.sv
module dual_reload_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  irq;
  logic        wave;

  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  dual_reload_timer u_dual_reload_timer (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .wave_o(wave)
  );

  // reference state
  int          m_pre;
  logic [15:0] m_cnt [2];
  logic [15:0] m_rld [2];
  logic [4:0]  m_ctrl;
  logic [1:0]  m_flag, m_arm;
  logic        m_wave;

  task automatic m_reset();
    m_pre = 0; m_ctrl = '0; m_flag = '0; m_arm = '0; m_wave = 1'b0;
    for (int i = 0; i < 2; i++) begin m_cnt[i] = 16'hFFFF; m_rld[i] = 16'hFFFF; end
  endtask

  task automatic m_step();
    logic        tk;
    logic [15:0] nc [2];
    logic [1:0]  nf, na, tcv;
    tk = (m_pre == 19);
    for (int i = 0; i < 2; i++) begin
      logic wc, wl, rc, rs;
      wc = wr && addr == 3'(2*i);
      wl = wr && addr == 3'(2*i+1);
      rc = rd && addr == 3'(2*i);
      rs = rd && addr == 3'd4;
      tcv[i] = tk && m_ctrl[i] && m_cnt[i] == 0 && !wc;
      if (wc) nc[i] = wdata;
      else if (tcv[i]) nc[i] = m_rld[i];
      else if (tk && m_ctrl[i]) nc[i] = m_cnt[i] - 1;
      else nc[i] = m_cnt[i];
      nf[i] = tcv[i] ? 1'b1 : (rc && m_arm[i]) ? 1'b0 : m_flag[i];
      na[i] = rs ? m_flag[i] : rc ? 1'b0 : m_arm[i];
      if (wl) m_rld[i] = wdata;
    end
    if (tcv[1] && m_ctrl[4]) m_wave = ~m_wave;
    if (wr && addr == 3'd4) m_ctrl = wdata[4:0];
    m_cnt[0] = nc[0]; m_cnt[1] = nc[1]; m_flag = nf; m_arm = na;
    m_pre = tk ? 0 : m_pre + 1;
  endtask

  function automatic logic [15:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return m_cnt[0];
      3'd1: return m_rld[0];
      3'd2: return m_cnt[1];
      3'd3: return m_rld[1];
      3'd4: return {6'd0, m_flag, 3'd0, m_ctrl};
      default: return 16'd0;
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_for(logic [2:0] a);
    case (a)
      3'd0, 3'd2: return "R3/R4/R9 counter";
      3'd1, 3'd3: return "R8 reload";
      3'd4:       return "R6/R10 control";
      default:    return "R10 unmapped";
    endcase
  endfunction

  task automatic check_all();
    check(tag_for(addr), rdata, m_read(addr));
    check("R5 irq", {14'd0, irq}, {14'd0, m_flag & m_ctrl[3:2]});
    check("R7 wave", {15'd0, wave}, {15'd0, m_wave});
  endtask

  // one bus cycle: drive at negedge, model at posedge, check at next negedge
  task automatic step(logic w, logic r, logic [2:0] a, logic [15:0] d);
    wr = w; rd = r; addr = a; wdata = d;
    @(posedge clk);
    m_step();
    @(negedge clk);
    check_all();
  endtask

  task automatic idle(int n, logic [2:0] a);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, a, 16'd0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [15:0] v0, v1;
    int t_last, t_now, cyc;
    logic w_prev;
    void'($urandom(32'd7151));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 cnt0", rdata, 16'hFFFF);
    addr = 3'd4; #1;
    check("R1 ctrl", rdata, 16'h0000);
    check("R1 irq", {14'd0, irq}, 16'd0);
    check("R1 wave", {15'd0, wave}, 16'd0);
    addr = 3'd3; #1;
    check("R1 rld1", rdata, 16'hFFFF);

    // R9 counter write visible next cycle
    step(1'b1, 1'b0, 3'd0, 16'd1000);
    check("R9 cnt0 write", rdata, 16'd1000);
    // R3 disabled hold across several ticks
    idle(60, 3'd0);
    check("R3 hold disabled", rdata, 16'd1000);
    // R2/R3 enabled: exactly one decrement per 20 clocks
    step(1'b1, 1'b0, 3'd4, 16'h0001);
    idle(5, 3'd0);
    v0 = rdata;
    idle(20, 3'd0);
    check("R2 one step per 20", rdata, v0 - 16'd1);
    // R8 reload write mid-run leaves count
    idle(3, 3'd0); v1 = rdata;
    step(1'b1, 1'b0, 3'd1, 16'd2);
    addr = 3'd0; #1;
    if (m_pre != 0) check("R8 count undisturbed", rdata, v1);
    // R4 terminal count and reload from new value
    step(1'b1, 1'b0, 3'd0, 16'd0);
    idle(25, 3'd4);
    check("R4 flag0 set", rdata & 16'h0100, 16'h0100);
    // R6: counter read without status read does not clear
    step(1'b1, 1'b0, 3'd4, 16'h0000);
    step(1'b0, 1'b1, 3'd0, 16'd0);
    addr = 3'd4; #1;
    check("R6 no clear w/o status", rdata & 16'h0100, 16'h0100);
    step(1'b0, 1'b1, 3'd4, 16'd0);
    step(1'b0, 1'b1, 3'd0, 16'd0);
    addr = 3'd4; #1;
    check("R6 cleared", rdata & 16'h0100, 16'h0000);
    // R5 irq when enabled flag
    step(1'b1, 1'b0, 3'd0, 16'd0);
    step(1'b1, 1'b0, 3'd4, 16'h0005);
    idle(25, 3'd0);
    check("R5 irq0", {14'd0, irq} & 16'd1, 16'd1);
    // R7 wave period: reload1=3 -> toggle every 80 clocks
    step(1'b1, 1'b0, 3'd4, 16'h0000);
    step(1'b1, 1'b0, 3'd3, 16'd3);
    step(1'b1, 1'b0, 3'd2, 16'd3);
    step(1'b1, 1'b0, 3'd4, 16'h0012);
    t_last = -1; cyc = 0; w_prev = wave;
    for (int k = 0; k < 400; k++) begin
      step(1'b0, 1'b0, 3'd2, 16'd0);
      cyc++;
      if (wave !== w_prev) begin
        t_now = cyc;
        if (t_last >= 0) check("R7 half period", 16'(t_now - t_last), 16'd80);
        t_last = t_now;
        w_prev = wave;
      end
    end
    // random phase
    for (int k = 0; k < 30000; k++) begin
      int op;
      logic [2:0] a;
      logic [15:0] d;
      op = $urandom_range(0, 9);
      a = 3'($urandom_range(0, 7));
      if (op < 5) step(1'b0, 1'b0, a, 16'd0);
      else if (op < 7) step(1'b0, 1'b1, a, 16'd0);
      else begin
        a = 3'($urandom_range(0, 4));
        if (a == 3'd4) d = 16'($urandom_range(0, 31));
        else if ($urandom_range(0, 7) == 0) d = 16'($urandom);
        else d = 16'($urandom_range(0, 7));
        step(1'b1, 1'b0, a, d);
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule